// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port reached through a simple memory-mapped register bus with single-cycle read and write strobes and a 4 KB address window. A direction register picks, pin by pin, whether the port drives a pin or listens to it. The data register is reached through a whole window of addresses rather than one offset. Word-address bits 9:2 of each access act as a per-bit mask. A program can therefore set, clear or test a single pin, or any group of pins, with one bus access and no read-modify-write.

Pins set as outputs drive their data bit. Pins set as inputs drive their output line high. Their external level passes through a two-flop synchronizer and is then loaded into the data register, where data-window reads see it. Each output line also has a one-cycle change strobe. The strobe marks the cycle after that line's resolved level moved.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the data and direction registers are 0, so every pin is an input. `pin_out` is 8'hFF, `pin_chg` is 0 and `rd_data` is 0.
- R2: A write at byte offset 0x400 loads the direction register from `wr_data[7:0]` and ignores the upper bus bits. A read at 0x400 returns it zero-extended. A direction bit of 1 makes that pin an output.
- R3: A read at any byte offset below 0x400 returns the data register ANDed with the mask `addr[9:2]`. Bit i of the mask is `addr[i+2]`. Every other bit of the 32-bit result reads 0.
- R4: A write at a byte offset below 0x400 changes a data bit only when that bit is set in the mask `addr[9:2]` and the pin is an output. All other data bits keep their value.
- R5: `pin_out[i]` equals data bit i when direction bit i is 1, and is 1 when direction bit i is 0.
- R6: An input pin's level reaches the data register through two synchronizer flops and one capture register. A level set before clock edge k is in the data register after edge k+2. The earliest read that returns it is strobed at edge k+3. Changes on `pin_in` of output pins are ignored.
- R7: `pin_chg[i]` is 1 for exactly one cycle, the cycle after the one in which `pin_out[i]` took a new value. Otherwise it is 0, including when only input pin levels move.
- R8: Writes at offsets above 0x400 change nothing. Reads there return 0.
- R9: Read data is registered. `rd_data` takes the addressed value at the clock edge where `rd_en` is sampled high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte offset within the window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Resolved pin output levels |
| pin_chg | output | 8 | Per-pin one-cycle change strobe |

## Verification
The bench writes data-window offsets whose mask covers both output and input pins. A design that ignored the direction term in the write mask would show the written bits on input pins at the next read. Reads at sparse masks such as offset 0x040 catch a design that returns the whole register or shifts the mask by the byte-lane bits. The bench also times an input change read by read. A design with a missing or extra synchronizer stage returns the new level one read early or one read late. The strobe check samples the cycles before, during and after a pulse, so a level instead of a pulse, or a pulse one cycle off, is caught. Writes at an offset above 0x400 with a wide upper word check that neither the direction register nor the data register moves.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Kind of register a bus offset selects
    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_DIR   = 2'd1,
        ACC_OTHER = 2'd2
    } acc_kind_e;

    // Classify a byte offset, given the size of the masked data window
    function automatic acc_kind_e decode_offset(input logic [31:0] ofs,
                                                input logic [31:0] win);
        if (ofs < win)
            return ACC_DATA;
        else if (ofs == win)
            return ACC_DIR;
        else
            return ACC_OTHER;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = pin_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_port_pkg::*;
#(
    parameter int W      = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [W-1:0]      sync_in,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [BUS_W-1:0]  rd_data
);

    // Size of the masked data window: one address per mask value, word spaced
    localparam int WIN_BYTES = 1 << (W + 2);
    localparam int MASK_LSB  = 2;
    localparam int MASK_MSB  = MASK_LSB + W - 1;

    typedef struct packed {
        logic [W-1:0]     data;
        logic [W-1:0]     dir;
        logic [BUS_W-1:0] rdata;
    } bank_t;

    bank_t st_d, st_q;

    acc_kind_e    kind;
    logic [W-1:0] acc_mask;
    logic [W-1:0] wr_sel;
    logic         unused_wr_hi;

    assign unused_wr_hi = ^wr_data[BUS_W-1:W];

    always_comb begin
        kind     = decode_offset(32'(addr), 32'(WIN_BYTES));
        acc_mask = addr[MASK_MSB:MASK_LSB];
        wr_sel   = (wr_en && kind == ACC_DATA) ? (acc_mask & st_q.dir) : '0;
    end

    always_comb begin
        st_d = st_q;

        // Data register: inputs follow the synchronized pins,
        // outputs follow masked writes
        for (int i = 0; i < W; i++) begin
            if (!st_q.dir[i])
                st_d.data[i] = sync_in[i];
            else if (wr_sel[i])
                st_d.data[i] = wr_data[i];
        end

        if (wr_en && kind == ACC_DIR)
            st_d.dir = wr_data[W-1:0];

        if (rd_en) begin
            unique case (kind)
                ACC_DATA:  st_d.rdata = BUS_W'(st_q.data & acc_mask);
                ACC_DIR:   st_d.rdata = BUS_W'(st_q.dir);
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign data_q  = st_q.data;
    assign dir_q   = st_q.dir;
    assign rd_data = st_q.rdata;

endmodule

// File: rtl/gpio_out_drive.sv
module gpio_out_drive #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_chg
);

    logic [W-1:0] level;

    typedef struct packed {
        logic [W-1:0] last;
        logic [W-1:0] chg;
    } drv_t;

    drv_t st_d, st_q;

    // Per-pin resolution: output pins drive data, input pins float high
    for (genvar g = 0; g < W; g++) begin : g_pin
        assign level[g] = dir_q[g] ? data_q[g] : 1'b1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.last = level;
        st_d.chg  = level ^ st_q.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= '1;
            st_q.chg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out = level;
    assign pin_chg = st_q.chg;

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
    parameter int W      = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_chg
);

    logic [W-1:0] sync_in;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;

    gpio_in_sync #(.W(W)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sync_out (sync_in)
    );

    gpio_bank #(.W(W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .sync_in (sync_in),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .rd_data (rd_data)
    );

    gpio_out_drive #(.W(W)) i_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pin_out (pin_out),
        .pin_chg (pin_chg)
    );

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
    parameter int W      = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wr_lo,
    input logic [BUS_W-1:0]  rd_data,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_chg,
    input logic [W-1:0]      data_q,
    input logic [W-1:0]      dir_q
);

    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(1 << (W + 2));

    logic [W-1:0]     amask;
    logic [BUS_W-1:0] amask_ext;
    assign amask     = addr[W+1:2];
    assign amask_ext = BUS_W'(amask);

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == WIN) |=> (dir_q == $past(wr_lo)));

    assert_read_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr < WIN) |=> ((rd_data & ~$past(amask_ext)) == '0));

    assert_write_confined_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < WIN) |=>
        (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(amask)) == '0));

    assert_input_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out | dir_q) == {W{1'b1}});

    assert_out_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ((data_q & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

    assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_chg == ($past(pin_out) ^ $past(pin_out, 2)));

    assert_other_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > WIN) |=> $stable(dir_q));

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rd_data));

endmodule

bind gpio_masked_port gpio_masked_port_chk #(.W(W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_lo   (wr_data[W-1:0]),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_chg (pin_chg),
    .data_q  (data_q),
    .dir_q   (dir_q)
);

// File: tb/test_gpio_masked_port.sv
module test_gpio_masked_port;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_chg;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    gpio_masked_port i_gpio_masked_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_chg (pin_chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WDOG_LIMIT) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WDOG_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [11:0] ofs;
        logic [31:0] wdat;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h400, 32'h0000_00F0, 32'h0, 4'd2},   // R2 upper pins out
        '{1'b0, 12'h400, 32'h0,         32'hF0, 4'd2},  // R2 read back
        '{1'b1, 12'h3FC, 32'hFFFF_FFFF, 32'h0, 4'd4},   // R4 full mask
        '{1'b0, 12'h3FC, 32'h0,         32'hF0, 4'd3},  // R3 full mask read
        '{1'b0, 12'h040, 32'h0,         32'h10, 4'd3},  // R3 single-bit mask
        '{1'b1, 12'h080, 32'h0,         32'h0, 4'd4},   // R4 clear bit 5 only
        '{1'b0, 12'h3FC, 32'h0,         32'hD0, 4'd4},  // R4 result
        '{1'b1, 12'h03C, 32'hFF,        32'h0, 4'd4},   // R4 mask on inputs only
        '{1'b0, 12'h3FC, 32'h0,         32'hD0, 4'd4},  // R4 inputs untouched
        '{1'b1, 12'h404, 32'hFFFF_FFAA, 32'h0, 4'd8},   // R8 stray write
        '{1'b0, 12'h400, 32'h0,         32'hF0, 4'd8},  // R8 dir unchanged
        '{1'b0, 12'h404, 32'h0,         32'h0, 4'd8},   // R8 stray read zero
        '{1'b1, 12'h400, 32'h1234_560F, 32'h0, 4'd2},   // R2 upper bits dropped
        '{1'b0, 12'h400, 32'h0,         32'h0F, 4'd2},  // R2 read back
        '{1'b0, 12'h3FC, 32'h0,         32'h00, 4'd6}   // R6 new inputs follow pins
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns after the next falling edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", 32'(pin_out), 32'hFF);
        check("R1 pin_chg", 32'(pin_chg), 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        bus_read(12'h400, rv); check("R1 dir", rv, 32'h0);
        bus_read(12'h3FC, rv); check("R1 data", rv, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].ofs, VEC[i].wdat);
            end else begin
                bus_read(VEC[i].ofs, rv);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].exp);
            end
        end
        repeat (2) @(negedge clk);

        // R5 inputs float high, outputs (data 0) low
        check("R5 pin_out", 32'(pin_out), 32'hF0);
        check("R9 rd_data held", rd_data, 32'h0);

        // R7 strobe after output change
        bus_write(12'h3FC, 32'h05);
        check("R5 pin_out after write", 32'(pin_out), 32'hF5);
        check("R7 no strobe yet", 32'(pin_chg), 32'h0);
        @(negedge clk);
        check("R7 strobe pulse", 32'(pin_chg), 32'h05);
        @(negedge clk);
        check("R7 strobe ends", 32'(pin_chg), 32'h0);

        // R6 input capture, output pins ignore their pin level
        pin_in = 8'h5A;
        repeat (4) @(negedge clk);
        check("R7 no strobe on inputs", 32'(pin_chg), 32'h0);
        bus_read(12'h3FC, rv); check("R6 capture", rv, 32'h55);
        check("R5 inputs still high", 32'(pin_out), 32'hF5);

        // R6 synchronizer latency, read by read
        pin_in = 8'hFF;
        bus_read(12'h3FC, rv); check("R6 latency edge1", rv, 32'h55);
        bus_read(12'h3FC, rv); check("R6 latency edge2", rv, 32'h55);
        bus_read(12'h3FC, rv); check("R6 latency edge3", rv, 32'h55);
        bus_read(12'h3FC, rv); check("R6 latency edge4", rv, 32'hF5);

        // R9 rd_data holds while no read
        repeat (3) @(negedge clk);
        check("R9 hold", rd_data, 32'hF5);

        // R3 sparse mask on input pins
        bus_read(12'h200, rv); check("R3 mask bit7", rv, 32'h80);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule